// File: doc/BRIEF.md
# Bus Traffic Performance Counter Unit

This block measures bus load for performance monitoring. It holds one free-running cycle counter and four event counters. Each event counter has a small select register that picks what it counts: read-data beats, write-data beats, both, or nothing. The beat inputs are single-cycle strobes from the bus being observed. When both strobes are high in one cycle and the select asks for both, the counter moves by two.

Software drives the block through a plain register port: word address, write enable, write data and a combinational read-data return. A global control register holds a run enable and two self-clearing reset bits, one for the event counters and one for the cycle counter. Each counter also has its own enable bit, which is turned on through a write-one-to-set register and turned off through a write-one-to-clear register. A typical session writes the control register once with both reset bits and the run enable set. This zeroes every counter and starts counting. To read, software clears the run enable, which freezes all counts, reads them, and then turns the individual enables off. The last event counter is wider than the others and is read as a low word plus a high part.

Top module: `pmon_unit`

## Requirements
- R1: After reset every mapped register reads zero: control, both enable views, all counters and all event selects.
- R2: The enable vector has bit 0 to bit 3 for event counters 0 to 3 and bit 4 for the cycle counter. Writing to address 0x1 sets the bits written as one. Writing to address 0x2 clears the bits written as one. Zero bits leave their enable unchanged. Reads at either address return the current vector.
- R3: A counter changes only while the run enable (control address 0x0, bit 0) and its own enable bit are both set, starting the cycle after the write that sets them. Clearing the run enable freezes every counter at its value. Setting it again resumes counting from that value.
- R4: Control bit 1 zeroes all event counters and control bit 2 zeroes the cycle counter, in the cycle of the write. Each acts independently, takes priority over counting, and always reads back as zero.
- R5: The event select of counter i is at address 0x9+i, bits [1:0]. The values are 00 for nothing, 01 for read beats, 10 for write beats and 11 for both. With 11, a cycle that has both strobes adds two. The select reads back as written.
- R6: The cycle counter (address 0x3) adds one for every cycle in which it is enabled under R3.
- R7: Event counters 0 to 2 (addresses 0x4 to 0x6) and the cycle counter are CNT_W bits wide. Event counter 3 is WIDE_W bits wide: its low CNT_W bits read at 0x7 and its upper WIDE_W-CNT_W bits read at 0x8. Every counter wraps to zero past its maximum, with no other effect.
- R8: Only manual start is built. The start-mode field, control bits [5:4], always reads zero, and writing it has no effect on counting.
- R9: Addresses 0xD to 0xF read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data, combinational from bus_addr |
| rd_beat | input | 1 | One read-data beat seen this cycle |
| wr_beat | input | 1 | One write-data beat seen this cycle |

## Verification
The assertions assume the beat strobes and the register port are clean, two-valued signals, sampled once per clock. They also assume that the address is held steady for as long as a read is observed. The stimulus changes every input only on the falling edge, reads one address per cycle with the write strobe low, and starts each counting window from a stopped state. As a result, the cycles counted per window are fixed by the write sequence. The bench uses narrow counter widths so that wrap and the carry into the wide counter's high part come up within a short run.

// File: rtl/pmon_pkg.sv
// Package pmon_pkg
// Shared constants for the bus performance counter unit: register word
// addresses, control bit positions and the event-select encoding.
// Assumes four event counters, the last of which is the wide one.
package pmon_pkg;

    localparam int NUM_EVT    = 4;
    localparam int A_CTRL     = 0;
    localparam int A_EN_SET   = 1;
    localparam int A_EN_CLR   = 2;
    localparam int A_CYC      = 3;
    localparam int A_EVT_BASE = 4;
    localparam int A_WIDE_LO  = A_EVT_BASE + NUM_EVT - 1;
    localparam int A_WIDE_HI  = A_WIDE_LO + 1;
    localparam int A_SEL_BASE = A_WIDE_HI + 1;
    localparam int A_LAST     = A_SEL_BASE + NUM_EVT - 1;
    localparam int ADDR_W     = $clog2(A_LAST + 1);

    localparam int C_RUN      = 0;
    localparam int C_EVT_RST  = 1;
    localparam int C_CYC_RST  = 2;

    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_RD   = 2'b01,
        SEL_WR   = 2'b10,
        SEL_BOTH = 2'b11
    } evt_sel_e;

endpackage

// File: rtl/pmon_regs.sv
// Module pmon_regs
// Holds the software-visible configuration: run enable, per-counter
// enables (set/clear views) and event selects. Produces the one-cycle
// counter clear pulses straight from the write that carries them.
// Assumes one register access per cycle on a word address.
module pmon_regs
    import pmon_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_we,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic                         glob_en,
    output logic [NUM_EVT:0]             cnt_en,
    output logic [NUM_EVT-1:0][1:0]      evt_sel,
    output logic                         evt_clr,
    output logic                         cyc_clr
);

    logic ctrl_hit;

    // Decode a write to the control word
    assign ctrl_hit = bus_we && (int'(bus_addr) == A_CTRL);
    // Self-clearing reset pulses, valid only in the write cycle
    assign evt_clr  = ctrl_hit && bus_wdata[C_EVT_RST];
    assign cyc_clr  = ctrl_hit && bus_wdata[C_CYC_RST];

    // Update configuration state on register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_en <= 1'b0;
            cnt_en  <= '0;
            evt_sel <= '0;
        end else if (bus_we) begin
            if (int'(bus_addr) == A_CTRL)
                glob_en <= bus_wdata[C_RUN];
            if (int'(bus_addr) == A_EN_SET)
                cnt_en <= cnt_en | bus_wdata[NUM_EVT:0];
            if (int'(bus_addr) == A_EN_CLR)
                cnt_en <= cnt_en & ~bus_wdata[NUM_EVT:0];
            for (int i = 0; i < NUM_EVT; i++) begin
                if (int'(bus_addr) == A_SEL_BASE + i)
                    evt_sel[i] <= bus_wdata[1:0];
            end
        end
    end

endmodule

// File: rtl/pmon_counter.sv
// Module pmon_counter
// Generic wrapping counter that adds a 0..2 step per cycle and clears
// synchronously. Clear has priority over the step.
// Assumes W >= 2.
module pmon_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [1:0]   step,
    output logic [W-1:0] value
);

    // Accumulate the step, wrapping silently at 2**W
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (clr)
            value <= '0;
        else
            value <= value + W'(step);
    end

endmodule

// File: rtl/pmon_unit.sv
// Module pmon_unit
// Bus performance counter unit: one cycle counter and NUM_EVT event
// counters with per-counter beat selection, a run enable, and a
// combinational register read port. The last event counter is WIDE_W
// bits and reads as a low CNT_W part plus a high part.
// Assumes CNT_W <= DATA_W, WIDE_W > CNT_W and WIDE_W - CNT_W <= DATA_W.
module pmon_unit
    import pmon_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int WIDE_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rd_beat,
    input  logic              wr_beat
);

    localparam int WIDE_IDX = NUM_EVT - 1;

    logic                              glob_en;
    logic [NUM_EVT:0]                  cnt_en;
    logic [NUM_EVT-1:0][1:0]           evt_sel;
    logic                              evt_clr;
    logic                              cyc_clr;
    logic [1:0]                        cyc_step;
    logic [CNT_W-1:0]                  cyc_cnt;
    logic [NUM_EVT-1:0][WIDE_W-1:0]    evt_cnt;

    pmon_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .glob_en   (glob_en),
        .cnt_en    (cnt_en),
        .evt_sel   (evt_sel),
        .evt_clr   (evt_clr),
        .cyc_clr   (cyc_clr)
    );

    // Cycle counter advances by one while running and enabled
    assign cyc_step = {1'b0, glob_en && cnt_en[NUM_EVT]};

    pmon_counter #(.W(CNT_W)) u_cyc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cyc_clr),
        .step  (cyc_step),
        .value (cyc_cnt)
    );

    for (genvar gi = 0; gi < NUM_EVT; gi++) begin : g_evt
        localparam int CW = (gi == WIDE_IDX) ? WIDE_W : CNT_W;
        logic [1:0]    step;
        logic [CW-1:0] val;

        // Beats picked by this counter's select, gated by both enables
        assign step = (glob_en && cnt_en[gi])
                    ? ({1'b0, rd_beat && evt_sel[gi][0]} + {1'b0, wr_beat && evt_sel[gi][1]})
                    : 2'd0;

        pmon_counter #(.W(CW)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (evt_clr),
            .step  (step),
            .value (val)
        );

        // Widen every counter to a common vector for the read mux
        assign evt_cnt[gi] = WIDE_W'(val);
    end

    // Register read mux; unmapped addresses return zero
    always_comb begin
        bus_rdata = '0;
        if (int'(bus_addr) == A_CTRL)
            bus_rdata[C_RUN] = glob_en;
        if (int'(bus_addr) == A_EN_SET || int'(bus_addr) == A_EN_CLR)
            bus_rdata[NUM_EVT:0] = cnt_en;
        if (int'(bus_addr) == A_CYC)
            bus_rdata = DATA_W'(cyc_cnt);
        for (int i = 0; i < WIDE_IDX; i++) begin
            if (int'(bus_addr) == A_EVT_BASE + i)
                bus_rdata = DATA_W'(evt_cnt[i][CNT_W-1:0]);
        end
        if (int'(bus_addr) == A_WIDE_LO)
            bus_rdata = DATA_W'(evt_cnt[WIDE_IDX][CNT_W-1:0]);
        if (int'(bus_addr) == A_WIDE_HI)
            bus_rdata = DATA_W'(evt_cnt[WIDE_IDX][WIDE_W-1:CNT_W]);
        for (int i = 0; i < NUM_EVT; i++) begin
            if (int'(bus_addr) == A_SEL_BASE + i)
                bus_rdata = DATA_W'(evt_sel[i]);
        end
    end

endmodule

// File: rtl/pmon_unit_chk.sv
// Module pmon_unit_chk
// Property checker bound into pmon_unit. It observes the register port and
// the internal enable, clear and counter state.
// Assumes the same parameters as the bound instance.
module pmon_unit_chk
    import pmon_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int WIDE_W = 40
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [ADDR_W-1:0]              bus_addr,
    input logic [DATA_W-1:0]              bus_rdata,
    input logic                           glob_en,
    input logic [NUM_EVT:0]               cnt_en,
    input logic                           evt_clr,
    input logic                           cyc_clr,
    input logic [CNT_W-1:0]               cyc_cnt,
    input logic [NUM_EVT-1:0][WIDE_W-1:0] evt_cnt
);

    AST_FREEZE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en && !evt_clr) |=> $stable(evt_cnt)); // R3

    AST_OWN_ENABLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en[0] && !evt_clr) |=> $stable(evt_cnt[0])); // R3

    AST_EVT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        evt_clr |=> (evt_cnt == '0)); // R4

    AST_CYC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_clr |=> (cyc_cnt == '0)); // R4

    AST_CYC_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_en && cnt_en[NUM_EVT] && !cyc_clr) |=> (cyc_cnt == CNT_W'($past(cyc_cnt) + 1'b1))); // R6

    AST_EVT_STEP_MAX_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_clr |=> (CNT_W'(evt_cnt[0][CNT_W-1:0] - $past(evt_cnt[0][CNT_W-1:0])) <= CNT_W'(2))); // R5

    AST_CTRL_READ_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_addr) == A_CTRL) |-> (bus_rdata[DATA_W-1:1] == '0)); // R8

    AST_EN_VIEW_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_addr) == A_EN_SET) |-> (bus_rdata == DATA_W'(cnt_en))); // R2

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_addr) > A_LAST) |-> (bus_rdata == '0)); // R9

endmodule

bind pmon_unit pmon_unit_chk #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .WIDE_W (WIDE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .glob_en   (glob_en),
    .cnt_en    (cnt_en),
    .evt_clr   (evt_clr),
    .cyc_clr   (cyc_clr),
    .cyc_cnt   (cyc_cnt),
    .evt_cnt   (evt_cnt)
);

// File: tb/pmon_unit_tb.sv
`timescale 1ns/1ps
// Directed bench for pmon_unit. Uses narrow counters so that wrap and the
// wide counter's high part can be reached in a short run.
module pmon_unit_tb;
    import pmon_pkg::*;

    localparam int TB_DATA_W = 32;
    localparam int TB_CNT_W  = 8;
    localparam int TB_WIDE_W = 12;
    localparam longint CMASK = (64'd1 << TB_CNT_W) - 1;
    localparam longint WMASK = (64'd1 << TB_WIDE_W) - 1;
    localparam longint HMASK = (64'd1 << (TB_WIDE_W - TB_CNT_W)) - 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 bus_we = 1'b0;
    logic [ADDR_W-1:0]    bus_addr = '0;
    logic [TB_DATA_W-1:0] bus_wdata = '0;
    logic [TB_DATA_W-1:0] bus_rdata;
    logic                 rd_beat = 1'b0;
    logic                 wr_beat = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    longint   exp_cyc;
    longint   exp_evt [NUM_EVT];
    logic [4:0] tb_en;
    logic [1:0] tb_sel [NUM_EVT];

    always #2.5 clk = ~clk;

    pmon_unit #(
        .DATA_W (TB_DATA_W),
        .CNT_W  (TB_CNT_W),
        .WIDE_W (TB_WIDE_W)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rd_beat   (rd_beat),
        .wr_beat   (wr_beat)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, expv);
        end
    endtask

    task automatic bus_write(int a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic check_reg(string tag, int a, logic [31:0] expv);
        @(negedge clk);
        bus_addr = ADDR_W'(a);
        #1;
        check(tag, bus_rdata, expv);
    endtask

    task automatic check_counters(string tag);
        check_reg({tag, " cycle"}, A_CYC, 32'(exp_cyc & CMASK));
        for (int i = 0; i < NUM_EVT - 1; i++)
            check_reg($sformatf("%s event%0d", tag, i), A_EVT_BASE + i, 32'(exp_evt[i] & CMASK));
        check_reg({tag, " R7 wide low"}, A_WIDE_LO, 32'((exp_evt[NUM_EVT-1] & WMASK) & CMASK));
        check_reg({tag, " R7 wide high"}, A_WIDE_HI,
                  32'(((exp_evt[NUM_EVT-1] & WMASK) >> TB_CNT_W) & HMASK));
    endtask

    // Start from a stopped state, stream m beat cycles, then stop again
    task automatic run_window(logic [31:0] start_ctrl, int m, int pat);
        if (start_ctrl[C_EVT_RST]) for (int i = 0; i < NUM_EVT; i++) exp_evt[i] = 0;
        if (start_ctrl[C_CYC_RST]) exp_cyc = 0;
        bus_write(A_CTRL, start_ctrl);
        for (int k = 0; k < m; k++) begin
            rd_beat = (pat == 1) ? 1'b1 : ((k % 3) != 0);
            wr_beat = (pat == 1) ? 1'b1 : ((k % 2) == 0);
            for (int i = 0; i < NUM_EVT; i++) begin
                if (tb_en[i])
                    exp_evt[i] += longint'(rd_beat && tb_sel[i][0]) + longint'(wr_beat && tb_sel[i][1]);
            end
            @(negedge clk);
        end
        rd_beat = 1'b0; wr_beat = 1'b0;
        bus_write(A_CTRL, 32'h0);
        if (tb_en[4]) exp_cyc += m + 2;
    endtask

    task automatic t_reset();
        for (int a = 0; a <= A_LAST; a++)
            check_reg($sformatf("R1 reset addr %0d", a), a, 32'h0);
    endtask

    task automatic t_enables();
        bus_write(A_EN_SET, 32'h15);
        check_reg("R2 set view", A_EN_SET, 32'h15);
        check_reg("R2 clear view", A_EN_CLR, 32'h15);
        bus_write(A_EN_SET, 32'h0A);
        check_reg("R2 set accumulates", A_EN_SET, 32'h1F);
        bus_write(A_EN_CLR, 32'h05);
        check_reg("R2 clear ones", A_EN_SET, 32'h1A);
        bus_write(A_EN_CLR, 32'h00);
        check_reg("R2 clear zeros no effect", A_EN_SET, 32'h1A);
        bus_write(A_EN_SET, 32'h1F);
        tb_en = 5'h1F;
        check_reg("R2 all on", A_EN_CLR, 32'h1F);
    endtask

    task automatic t_select();
        tb_sel[0] = SEL_RD; tb_sel[1] = SEL_WR; tb_sel[2] = SEL_BOTH; tb_sel[3] = SEL_BOTH;
        for (int i = 0; i < NUM_EVT; i++) bus_write(A_SEL_BASE + i, 32'(tb_sel[i]));
        for (int i = 0; i < NUM_EVT; i++)
            check_reg($sformatf("R5 select%0d readback", i), A_SEL_BASE + i, 32'(tb_sel[i]));
    endtask

    task automatic t_gated();
        rd_beat = 1'b1; wr_beat = 1'b1;
        repeat (10) @(negedge clk);
        rd_beat = 1'b0; wr_beat = 1'b0;
        check_counters("R3 run off");
    endtask

    task automatic t_ctrl();
        bus_write(A_CTRL, 32'h37);
        check_reg("R4 R8 ctrl readback", A_CTRL, 32'h1);
        bus_write(A_CTRL, 32'h06);
        for (int i = 0; i < NUM_EVT; i++) exp_evt[i] = 0;
        exp_cyc = 0;
        check_reg("R3 run cleared", A_CTRL, 32'h0);
        check_counters("R4 both cleared");
    endtask

    task automatic t_pattern();
        run_window(32'h07, 20, 0);
        check_counters("R5 R6 pattern");
    endtask

    task automatic t_resume();
        run_window(32'h01, 10, 0);
        check_counters("R3 resume");
    endtask

    task automatic t_partial_reset();
        bus_write(A_CTRL, 32'h04);
        exp_cyc = 0;
        check_counters("R4 cycle only");
        bus_write(A_CTRL, 32'h02);
        for (int i = 0; i < NUM_EVT; i++) exp_evt[i] = 0;
        check_counters("R4 events only");
    endtask

    task automatic t_subset();
        bus_write(A_EN_CLR, 32'h15);
        tb_en = 5'h0A;
        run_window(32'h07, 15, 0);
        check_counters("R3 subset");
        bus_write(A_EN_SET, 32'h1F);
        tb_en = 5'h1F;
    endtask

    task automatic t_wrap();
        run_window(32'h07, 700, 1);
        check_counters("R7 wrap");
    endtask

    task automatic t_unmapped();
        for (int a = A_LAST + 1; a < (1 << ADDR_W); a++) bus_write(a, 32'hFFFF_FFFF);
        for (int a = A_LAST + 1; a < (1 << ADDR_W); a++)
            check_reg($sformatf("R9 unmapped read %0d", a), a, 32'h0);
        check_reg("R9 ctrl untouched", A_CTRL, 32'h0);
        check_reg("R9 enables untouched", A_EN_SET, 32'h1F);
        for (int i = 0; i < NUM_EVT; i++)
            check_reg($sformatf("R9 select%0d untouched", i), A_SEL_BASE + i, 32'(tb_sel[i]));
        check_counters("R9 counters untouched");
    endtask

    initial begin
        exp_cyc = 0;
        for (int i = 0; i < NUM_EVT; i++) begin exp_evt[i] = 0; tb_sel[i] = SEL_NONE; end
        tb_en = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enables();
        t_select();
        t_gated();
        t_ctrl();
        t_pattern();
        t_resume();
        t_partial_reset();
        t_subset();
        t_wrap();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
        $finish;
    end

endmodule